// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block serves configuration requests from the issue stage of a variable-length vector engine. Each request carries the number of elements the program still wants to process and a type word. The type word selects an element width and a register-grouping factor. The unit checks the type word and works out how many elements fit in one register group. It then grants an active length and holds that length, together with the accepted type, as the current configuration. A new configuration takes effect on the clock edge that accepts it, so a program may reconfigure before any vector instruction at no extra cost.

The grant is not always the plain minimum of the request and the group capacity. A balancing option spreads a short tail evenly over the last two iterations of a loop. A continuation flag keeps the grant from growing while a loop runs with an unchanged type. A keep-length flag changes the type but preserves the current length. A separate fault-first event lets the load unit cut the active length back to the first element it could not reach.

Top module: `vlcfg_unit`

## Requirements
- R1: The type word is 8 bits. Bits [1:0] hold a grouping code m, and the grouping factor is 1<<m (1, 2, 4 or 8). Bits [4:2] hold a width code w, and the element width is 8<<w bits. For a legal word, rsp_sew reports the width in bits and rsp_lmul reports the grouping factor.
- R2: A type word is illegal when any of bits [7:5] is set, or when its element width exceeds ELEN_MAX. An illegal request reports rsp_len, rsp_vlmax, rsp_sew and rsp_lmul as 0, sets vl_o to 0 and sets illegal_o. illegal_o stays set until a legal request is accepted.
- R3: For a legal word, rsp_vlmax equals REG_BITS times the grouping factor divided by the element width.
- R4: With no option flags set, the grant equals the smaller of req_avl and the group capacity.
- R5: With req_balance set, a request above the capacity but no more than twice the capacity is granted ceil(req_avl/2). Other requests are granted as in R4.
- R6: With req_chain set, a type word equal to the current legal one and req_keep clear, the grant is also limited to the current vl_o, so it never increases.
- R7: With req_keep set and a legal word, the grant is the smaller of the current vl_o and the new capacity. req_avl and req_balance have no effect.
- R8: A ff_valid pulse with 0 < ff_index < vl_o, in a cycle with no accepted request, sets vl_o to ff_index on the next edge. Any other index is ignored. An accepted request in the same cycle takes precedence.
- R9: vl_o changes only on an accepted request or on a trim as in R8.
- R10: req_ready is always 1. rsp_valid is high for exactly the cycle after each accepted request. The result ports and vl_o are registered on the accepting edge. Reset clears vl_o, rsp_valid and the result ports and sets illegal_o (no configuration yet).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_avl | input | AVL_W | Requested element count |
| req_vtype | input | 8 | Type word |
| req_balance | input | 1 | Spread the tail over two iterations |
| req_chain | input | 1 | Request continues the current loop |
| req_keep | input | 1 | Keep the current length, change only the type |
| ff_valid | input | 1 | Fault-first trim event |
| ff_index | input | VLMAX_W | Index of the first inaccessible element |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_len | output | VLMAX_W | Granted length |
| rsp_sew | output | 11 | Element width in bits |
| rsp_lmul | output | 4 | Grouping factor |
| rsp_vlmax | output | VLMAX_W | Group capacity in elements |
| vl_o | output | VLMAX_W | Current active length |
| illegal_o | output | 1 | Current configuration is illegal |

## Verification
The hardest condition to reach from the ports is the interplay of history-dependent grants. A chained request is clamped only when the stored type matches and the stored state is legal. A keep-length request depends on a length that may have been trimmed earlier by a fault event. The stimulus therefore runs a long pseudo-random mix of chained, keep, balanced and illegal requests, interleaved with trim events, against a bench model that tracks length, type and legality. Before that, exhaustive sweeps cover every type word and a dense range of requested lengths on each legal type.

// File: rtl/vlcfg_pkg.sv
`timescale 1ns/1ps
package vlcfg_pkg;
  localparam int VTYPE_W   = 8;
  localparam int MCODE_LSB = 0;
  localparam int WCODE_LSB = 2;
  localparam int RSV_LSB   = 5;
  localparam int SEW_W     = 11;
  localparam int LMUL_W    = 4;

  // element width in bits for a width code
  function automatic int unsigned sew_of(input logic [2:0] w);
    return 32'd8 << w;
  endfunction

  // grouping factor for a grouping code
  function automatic int unsigned lmul_of(input logic [1:0] m);
    return 32'd1 << m;
  endfunction

  // reg_bits * (1<<m) / (8<<w), as shifts
  function automatic int unsigned vlmax_of(input int unsigned reg_bits,
                                           input logic [2:0] w,
                                           input logic [1:0] m);
    return (reg_bits << m) >> (32'(w) + 32'd3);
  endfunction

  function automatic int unsigned ceil_half(input int unsigned a);
    return (a >> 1) + (a & 32'd1);
  endfunction
endpackage

// File: rtl/vlcfg_decode.sv
`timescale 1ns/1ps
module vlcfg_decode
  import vlcfg_pkg::*;
#(
  parameter int REG_BITS = 128,
  parameter int ELEN_MAX = 64,
  parameter int VLMAX_W  = 8
) (
  input  logic [VTYPE_W-1:0] vtype,
  output logic               legal,
  output logic [SEW_W-1:0]   sew,
  output logic [LMUL_W-1:0]  lmul,
  output logic [VLMAX_W-1:0] vlmax
);
  logic [2:0] wcode;
  logic [1:0] mcode;
  logic       rsv_set;
  logic [7:0] width_ok;

  assign wcode   = vtype[WCODE_LSB +: 3];
  assign mcode   = vtype[MCODE_LSB +: 2];
  assign rsv_set = |vtype[VTYPE_W-1:RSV_LSB];

  // per-code legality against the implementation width limit
  for (genvar i = 0; i < 8; i++) begin : g_wok
    assign width_ok[i] = (sew_of(3'(i)) <= ELEN_MAX);
  end

  always_comb begin
    legal = !rsv_set && width_ok[wcode];
    if (legal) begin
      sew   = SEW_W'(sew_of(wcode));
      lmul  = LMUL_W'(lmul_of(mcode));
      vlmax = VLMAX_W'(vlmax_of(REG_BITS, wcode, mcode));
    end else begin
      sew   = '0;
      lmul  = '0;
      vlmax = '0;
    end
  end
endmodule

// File: rtl/vlcfg_grant.sv
`timescale 1ns/1ps
module vlcfg_grant
  import vlcfg_pkg::*;
#(
  parameter int AVL_W   = 12,
  parameter int VLMAX_W = 8
) (
  input  logic               legal,
  input  logic [VLMAX_W-1:0] vlmax,
  input  logic [AVL_W-1:0]   avl,
  input  logic               balance,
  input  logic               keep,
  input  logic               clamp_en,
  input  logic [VLMAX_W-1:0] cur_vl,
  output logic [VLMAX_W-1:0] grant,
  output logic               bal_hit
);
  logic [AVL_W-1:0]   max_w;
  logic [AVL_W-1:0]   twice_w;
  logic [VLMAX_W-1:0] plain;
  logic [VLMAX_W-1:0] half;
  logic [VLMAX_W-1:0] base;
  logic [VLMAX_W-1:0] kept;

  always_comb begin
    max_w   = AVL_W'(vlmax);
    twice_w = max_w << 1;
    plain   = (avl < max_w) ? VLMAX_W'(avl) : vlmax;
    bal_hit = balance && (avl > max_w) && (avl <= twice_w);
    half    = VLMAX_W'(ceil_half(32'(avl)));
    base    = bal_hit ? half : plain;
    kept    = (cur_vl < vlmax) ? cur_vl : vlmax;
    if (!legal)                          grant = '0;
    else if (keep)                       grant = kept;
    else if (clamp_en && base > cur_vl)  grant = cur_vl;
    else                                 grant = base;
  end
endmodule

// File: rtl/vlcfg_unit.sv
`timescale 1ns/1ps
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int REG_BITS = 128,
  parameter int ELEN_MAX = 64,
  parameter int AVL_W    = 12,
  localparam int VLMAX_W = $clog2(REG_BITS) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AVL_W-1:0]   req_avl,
  input  logic [7:0]         req_vtype,
  input  logic               req_balance,
  input  logic               req_chain,
  input  logic               req_keep,
  input  logic               ff_valid,
  input  logic [VLMAX_W-1:0] ff_index,
  output logic               rsp_valid,
  output logic [VLMAX_W-1:0] rsp_len,
  output logic [10:0]        rsp_sew,
  output logic [3:0]         rsp_lmul,
  output logic [VLMAX_W-1:0] rsp_vlmax,
  output logic [VLMAX_W-1:0] vl_o,
  output logic               illegal_o
);
  logic               req_fire;
  logic               dec_legal;
  logic [SEW_W-1:0]   dec_sew;
  logic [LMUL_W-1:0]  dec_lmul;
  logic [VLMAX_W-1:0] dec_vlmax;
  logic [VLMAX_W-1:0] grant;
  logic               bal_hit;
  logic               clamp_en;
  logic               ff_trim;
  logic [VLMAX_W-1:0] vl_q;
  logic               ill_q;
  logic [7:0]         vt_q;

  assign req_ready = 1'b1;
  assign req_fire  = req_valid && req_ready;
  assign clamp_en  = req_chain && !req_keep && !ill_q && (req_vtype == vt_q);
  assign ff_trim   = ff_valid && !req_fire && (ff_index != '0) && (ff_index < vl_q);

  vlcfg_decode #(
    .REG_BITS(REG_BITS), .ELEN_MAX(ELEN_MAX), .VLMAX_W(VLMAX_W)
  ) i_decode (
    .vtype(req_vtype), .legal(dec_legal), .sew(dec_sew),
    .lmul(dec_lmul), .vlmax(dec_vlmax)
  );

  vlcfg_grant #(
    .AVL_W(AVL_W), .VLMAX_W(VLMAX_W)
  ) i_grant (
    .legal(dec_legal), .vlmax(dec_vlmax), .avl(req_avl),
    .balance(req_balance), .keep(req_keep), .clamp_en(clamp_en),
    .cur_vl(vl_q), .grant(grant), .bal_hit(bal_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q      <= '0;
      ill_q     <= 1'b1;
      vt_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_len   <= '0;
      rsp_sew   <= '0;
      rsp_lmul  <= '0;
      rsp_vlmax <= '0;
    end else begin
      rsp_valid <= req_fire;
      if (req_fire) begin
        vl_q      <= grant;
        ill_q     <= !dec_legal;
        vt_q      <= req_vtype;
        rsp_len   <= grant;
        rsp_sew   <= dec_sew;
        rsp_lmul  <= dec_lmul;
        rsp_vlmax <= dec_vlmax;
      end else if (ff_trim) begin
        vl_q <= ff_index;
      end
    end
  end

  assign vl_o      = vl_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/vlcfg_chk.sv
`timescale 1ns/1ps
module vlcfg_chk #(
  parameter int VLMAX_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_fire,
  input logic               ff_trim,
  input logic               clamp_en,
  input logic [VLMAX_W-1:0] ff_index,
  input logic               rsp_valid,
  input logic [VLMAX_W-1:0] rsp_len,
  input logic [VLMAX_W-1:0] rsp_vlmax,
  input logic [VLMAX_W-1:0] vl_o,
  input logic               illegal_o
);
  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid);
  assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_fire |=> !rsp_valid);
  assert_len_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_len == vl_o);
  assert_within_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_len <= rsp_vlmax);
  assert_illegal_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && illegal_o) |-> (rsp_len == '0 && rsp_vlmax == '0 && vl_o == '0));
  assert_vl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_fire && !ff_trim) |=> $stable(vl_o));
  assert_trim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ff_trim |=> vl_o == $past(ff_index));
  assert_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && clamp_en) |=> vl_o <= $past(vl_o));
endmodule

bind vlcfg_unit vlcfg_chk #(.VLMAX_W(VLMAX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .ff_trim(ff_trim),
  .clamp_en(clamp_en), .ff_index(ff_index), .rsp_valid(rsp_valid),
  .rsp_len(rsp_len), .rsp_vlmax(rsp_vlmax), .vl_o(vl_o), .illegal_o(illegal_o)
);

// File: tb/test_vlcfg_unit.sv
`timescale 1ns/1ps
module test_vlcfg_unit;
  localparam int REG_BITS = 128;
  localparam int ELEN_MAX = 64;
  localparam int AVL_W    = 12;
  localparam int VLW      = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [AVL_W-1:0] req_avl = '0;
  logic [7:0]     req_vtype = '0;
  logic           req_balance = 1'b0;
  logic           req_chain = 1'b0;
  logic           req_keep = 1'b0;
  logic           ff_valid = 1'b0;
  logic [VLW-1:0] ff_index = '0;
  logic           rsp_valid;
  logic [VLW-1:0] rsp_len;
  logic [10:0]    rsp_sew;
  logic [3:0]     rsp_lmul;
  logic [VLW-1:0] rsp_vlmax;
  logic [VLW-1:0] vl_o;
  logic           illegal_o;

  always #2.5 clk = ~clk;

  vlcfg_unit #(.REG_BITS(REG_BITS), .ELEN_MAX(ELEN_MAX), .AVL_W(AVL_W)) i_vlcfg_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_avl(req_avl), .req_vtype(req_vtype), .req_balance(req_balance),
    .req_chain(req_chain), .req_keep(req_keep), .ff_valid(ff_valid),
    .ff_index(ff_index), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
    .rsp_sew(rsp_sew), .rsp_lmul(rsp_lmul), .rsp_vlmax(rsp_vlmax),
    .vl_o(vl_o), .illegal_o(illegal_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int m_vl = 0;
  bit m_ill = 1;
  logic [7:0] m_vt = '0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int e_sew(input logic [7:0] vt);
    return 8 * (2 ** int'(vt[4:2]));
  endfunction
  function automatic int e_mult(input logic [7:0] vt);
    return 2 ** int'(vt[1:0]);
  endfunction
  function automatic bit e_legal(input logic [7:0] vt);
    return (vt[7:5] == 3'd0) && (e_sew(vt) <= ELEN_MAX);
  endfunction
  function automatic int e_max(input logic [7:0] vt);
    return e_legal(vt) ? (REG_BITS * e_mult(vt)) / e_sew(vt) : 0;
  endfunction

  task automatic request(input logic [7:0] vt, input int avl, input bit bal,
                         input bit chain, input bit keep, input int ff_same);
    int vm, g;
    string tag;
    vm = e_max(vt);
    if (!e_legal(vt)) begin g = 0; tag = "R2"; end
    else if (keep) begin g = (m_vl < vm) ? m_vl : vm; tag = "R7"; end
    else begin
      if (bal && avl > vm && avl <= 2 * vm) begin g = (avl + 1) / 2; tag = "R5"; end
      else begin g = (avl < vm) ? avl : vm; tag = "R4"; end
      if (chain && !m_ill && vt == m_vt && g > m_vl) begin g = m_vl; tag = "R6"; end
    end
    @(negedge clk);
    req_valid = 1'b1; req_vtype = vt; req_avl = AVL_W'(avl);
    req_balance = bal; req_chain = chain; req_keep = keep;
    if (ff_same >= 0) begin ff_valid = 1'b1; ff_index = VLW'(ff_same); end
    @(negedge clk);
    req_valid = 1'b0; ff_valid = 1'b0;
    if (ff_same >= 0) tag = "R8";
    check("R10", "rsp_valid", int'(rsp_valid), 1);
    check(tag, "rsp_len", int'(rsp_len), g);
    check(tag, "vl_o", int'(vl_o), g);
    check("R2", "illegal_o", int'(illegal_o), e_legal(vt) ? 0 : 1);
    check("R3", "rsp_vlmax", int'(rsp_vlmax), vm);
    check("R1", "rsp_sew", int'(rsp_sew), e_legal(vt) ? e_sew(vt) : 0);
    check("R1", "rsp_lmul", int'(rsp_lmul), e_legal(vt) ? e_mult(vt) : 0);
    m_vl = g; m_ill = !e_legal(vt); m_vt = vt;
  endtask

  task automatic trim(input int idx);
    string tag;
    tag = "R9";
    @(negedge clk);
    ff_valid = 1'b1; ff_index = VLW'(idx);
    @(negedge clk);
    ff_valid = 1'b0;
    if (idx > 0 && idx < m_vl) begin m_vl = idx; tag = "R8"; end
    check(tag, "vl_o after fault event", int'(vl_o), m_vl);
    check("R10", "rsp_valid idle", int'(rsp_valid), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      check("R9", "vl_o idle", int'(vl_o), m_vl);
      check("R10", "rsp_valid idle", int'(rsp_valid), 0);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", "reset rsp_valid", int'(rsp_valid), 0);
    check("R10", "reset vl_o", int'(vl_o), 0);
    check("R10", "reset illegal_o", int'(illegal_o), 1);
    check("R10", "req_ready", int'(req_ready), 1);
    check("R10", "reset rsp_len", int'(rsp_len), 0);

    // R1 R2 R3: every type word
    for (int vt = 0; vt < 256; vt++) request(8'(vt), 100, 0, 0, 0, -1);

    // R4 R5: dense length sweep over all legal types
    for (int w = 0; w < 4; w++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 270; a += 7) begin
          request({3'b000, 3'(w), 2'(m)}, a, 0, 0, 0, -1);
          request({3'b000, 3'(w), 2'(m)}, a, 1, 0, 0, -1);
        end

    // R5 worked case: capacity 64, request 72 -> 36, then 36
    request({3'b000, 3'd0, 2'd2}, 72, 1, 0, 0, -1);
    check("R5", "balanced grant 72/64", int'(rsp_len), 36);
    request({3'b000, 3'd0, 2'd2}, 36, 1, 1, 0, -1);
    // R5 edge: exactly twice and one above twice
    request({3'b000, 3'd0, 2'd2}, 128, 1, 0, 0, -1);
    request({3'b000, 3'd0, 2'd2}, 129, 1, 0, 0, -1);

    // R6: chained request tries to grow
    request({3'b000, 3'd1, 2'd1}, 5, 0, 0, 0, -1);
    request({3'b000, 3'd1, 2'd1}, 200, 0, 1, 0, -1);
    check("R6", "chained grant stays", int'(vl_o), 5);
    request({3'b000, 3'd2, 2'd1}, 200, 0, 1, 0, -1); // type changed: no clamp

    // R7: keep length across a type change that shrinks capacity
    request({3'b000, 3'd0, 2'd3}, 100, 0, 0, 0, -1);
    request({3'b000, 3'd3, 2'd0}, 7, 1, 0, 1, -1);
    check("R7", "kept length clamped", int'(vl_o), 2);

    // R8: trims and ignored indices
    request({3'b000, 3'd0, 2'd1}, 30, 0, 0, 0, -1);
    trim(0); trim(30); trim(40); trim(12); trim(11);
    check("R8", "trimmed length", int'(vl_o), 11);
    request({3'b000, 3'd0, 2'd1}, 25, 0, 0, 0, 3); // request wins
    idle(3);

    // R2 sticky illegal then recovery
    request(8'hE0, 50, 0, 0, 0, -1);
    idle(2);
    check("R2", "illegal held", int'(illegal_o), 1);
    request(8'h00, 50, 0, 1, 0, -1);

    // mixed pseudo-random history
    lfsr = 16'hACE1;
    for (int i = 0; i < 500; i++) begin
      logic [7:0] vt;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      vt = {(lfsr[15:12] == 4'hF) ? 3'b010 : 3'b000, lfsr[2] ? 3'd4 : {1'b0, lfsr[1:0]}, lfsr[4:3]};
      if (lfsr[11:10] == 2'b00) vt = m_vt;
      if (lfsr[9:8] == 2'b11) trim(int'(lfsr[14:9]) % 40);
      request(vt, int'(lfsr[13:5]) % 300, lfsr[5], lfsr[6] | lfsr[7], lfsr[12:11] == 2'b11,
              (lfsr[15:14] == 2'b10) ? 2 : -1);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule